// File: doc/BRIEF.md
# Dead-Time Gate Sequencer with Start-up Hold-off

This block sits between a commutation or PWM stage and the gate drivers of a three-leg power bridge. For every leg it receives a request for the upper switch and a request for the lower switch, and it produces the two gate enables that are actually driven. A switch turns off on the first clock edge after its request drops. A switch turns on only after a dead-time delay. Because the complementary switch is released before that delay starts, both switches of one leg are never on together.

The dead time comes from one of two sources, chosen by a strap input. It is either a programmed count of clock cycles, or a fixed default of 6 µs that is converted to cycles from the clock-frequency parameter. After reset is released, every gate is held off for a settling interval. That interval is a parameter in microseconds and is also converted to cycles, with 3 ms as the default. It covers the time the gate supply needs to come up.

There is no limit on how long a switch may stay on, so an upper switch can be held on continuously for 100 % duty. All pins are plain control levels sampled on every clock. There is no data stream, so no valid/ready handshake and no back-pressure exist.

Top module: `gate_deadtime_seq`

## Requirements
- R1: In any leg, the upper and lower gate enables are never high in the same cycle.
- R2: Take D as the effective dead time in cycles. A gate enable rises on the (D+1)-th rising clock edge, counting the first edge that samples its own request high with the opposite request low. If the opposite gate was on, it stays off for at least D cycles before that rise.
- R3: A gate enable falls on the first clock edge that samples its request low. If the request drops before the enable has risen, the turn-on is cancelled, and a later request starts the delay again from zero.
- R4: While both requests of one leg are high, both gate enables of that leg are low from the next clock edge onward.
- R5: With `dt_use_default` low, D equals `dt_cycles`. With it high, D equals the number of clock cycles in 6 µs at the parameterized clock frequency, and `dt_cycles` has no effect.
- R6: While `rst_n` is low, every gate enable is low at once, without waiting for a clock edge.
- R7: After `rst_n` rises, every gate enable stays low through the HOLD-th rising edge, where HOLD is the hold-off time in cycles. A request held from release makes its enable rise on edge HOLD+1+D.
- R8: An enable whose request stays high and whose opposite request stays low remains high for as long as that holds, with no forced off-time.
- R9: Each leg's enables depend only on that leg's own requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_hi | input | N_PH | Upper-switch turn-on request, one bit per leg |
| req_lo | input | N_PH | Lower-switch turn-on request, one bit per leg |
| dt_cycles | input | DT_W | Programmed dead time in clock cycles |
| dt_use_default | input | 1 | Strap: 1 selects the fixed 6 µs dead time |
| gate_hi | output | N_PH | Upper gate enables |
| gate_lo | output | N_PH | Lower gate enables |

## Verification
The bench builds the block with a 4-bit dead-time field and a nominal 1 MHz clock-frequency parameter. This makes the default dead time 6 cycles and the hold-off 20 cycles. With these values the bench can sweep every programmable dead time from 0 to 15, plus the strapped default, in both switching directions on all three legs. It also reaches the boundary where a request is withdrawn exactly one edge short of its turn-on, and it can measure the full start-up hold-off twice: once at power-up and once after a reset in mid-run.

// File: rtl/gdt_pkg.sv
package gdt_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/gdt_holdoff.sv
module gdt_holdoff #(
  parameter int unsigned HOLD_CYC = 375000
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  localparam int unsigned LIM = (HOLD_CYC == 0) ? 1 : HOLD_CYC;
  localparam int unsigned HW  = $clog2(LIM + 1);

  logic [HW-1:0] cnt_q;

  // run rises on the LIM-th edge after reset release and then stays set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run   <= 1'b0;
    end else if (!run) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == HW'(LIM - 1)) run <= 1'b1;
    end
  end

  assert_run_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> run);
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= HW'(LIM));
endmodule

// File: rtl/gdt_dt_select.sv
module gdt_dt_select #(
  parameter int unsigned DT_W    = 8,
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned DEF_CYC = 750
) (
  input  logic [DT_W-1:0]  dt_prog,
  input  logic             use_def,
  output logic [CNT_W-1:0] dt_eff
);
  logic [CNT_W-1:0] prog_ext;

  generate
    if (CNT_W > DT_W) begin : g_pad
      assign prog_ext = {{(CNT_W - DT_W){1'b0}}, dt_prog};
    end else begin : g_same
      assign prog_ext = dt_prog;
    end
  endgenerate

  assign dt_eff = use_def ? CNT_W'(DEF_CYC) : prog_ext;
endmodule

// File: rtl/gdt_leg.sv
module gdt_leg #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             req_hi,
  input  logic             req_lo,
  input  logic [CNT_W-1:0] dt_eff,
  output logic             gate_hi,
  output logic             gate_lo
);
  // side 0 = upper switch, side 1 = lower switch
  logic [1:0] req;
  logic [1:0] want;
  logic [1:0] g;

  assign req = {req_lo, req_hi};

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic             g_q;
    logic [CNT_W-1:0] cnt_q;

    assign want[s] = run & req[s] & ~req[1-s];
    assign g[s]    = g_q;

    // delay counter restarts whenever this side's turn-on condition lapses
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        g_q   <= 1'b0;
        cnt_q <= '0;
      end else begin
        g_q <= want[s] & (g_q | (cnt_q >= dt_eff));
        if (!want[s])
          cnt_q <= '0;
        else if (!g_q && (cnt_q != '1))
          cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign gate_hi = g[0];
  assign gate_lo = g[1];

  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));
  assert_bbm_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_lo && dt_eff != '0) |=> !gate_hi);
  assert_bbm_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi && dt_eff != '0) |=> !gate_lo);
  assert_off_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_hi |=> !gate_hi);
  assert_off_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_lo |=> !gate_lo);
  assert_conflict_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hi && req_lo) |=> !(gate_hi || gate_lo));
  assert_hold_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi && req_hi && !req_lo && run) |=> gate_hi);
endmodule

// File: rtl/gate_deadtime_seq.sv
module gate_deadtime_seq #(
  parameter int unsigned N_PH      = 3,
  parameter int unsigned DT_W      = 8,
  parameter int unsigned CLK_KHZ   = 125000,
  parameter int unsigned HOLD_US   = 3000,
  parameter int unsigned DEF_DT_NS = 6000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_PH-1:0] req_hi,
  input  logic [N_PH-1:0] req_lo,
  input  logic [DT_W-1:0] dt_cycles,
  input  logic            dt_use_default,
  output logic [N_PH-1:0] gate_hi,
  output logic [N_PH-1:0] gate_lo
);
  localparam int unsigned HOLD_CYC = CLK_KHZ * HOLD_US / 1000;
  localparam int unsigned DEF_CYC  = CLK_KHZ * DEF_DT_NS / 1000000;
  localparam int unsigned DT_MAX   = (1 << DT_W) - 1;
  localparam int unsigned CNT_W    = $clog2(gdt_pkg::max_u(DT_MAX, DEF_CYC) + 1);

  logic             run;
  logic [CNT_W-1:0] dt_eff;

  gdt_pkg::gate_pair_t leg_out [N_PH];

  gdt_holdoff #(.HOLD_CYC(HOLD_CYC)) u_holdoff (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run)
  );

  gdt_dt_select #(.DT_W(DT_W), .CNT_W(CNT_W), .DEF_CYC(DEF_CYC)) u_dtsel (
    .dt_prog(dt_cycles),
    .use_def(dt_use_default),
    .dt_eff (dt_eff)
  );

  for (genvar p = 0; p < N_PH; p++) begin : g_leg
    gdt_leg #(.CNT_W(CNT_W)) u_leg (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .req_hi (req_hi[p]),
      .req_lo (req_lo[p]),
      .dt_eff (dt_eff),
      .gate_hi(leg_out[p].hi),
      .gate_lo(leg_out[p].lo)
    );
    assign gate_hi[p] = leg_out[p].hi;
    assign gate_lo[p] = leg_out[p].lo;
  end

  assert_holdoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (gate_hi == '0 && gate_lo == '0));
  assert_reset_R6: assert property (@(posedge clk)
    !rst_n |-> (gate_hi == '0 && gate_lo == '0));
endmodule

// File: tb/gate_deadtime_seq_tb.sv
`timescale 1ns/1ps
module gate_deadtime_seq_tb;
  localparam int N_PH = 3;
  localparam int DT_W = 4;
  localparam int HOLD = 20;  // 1000 kHz * 20 us
  localparam int DEF  = 6;   // 1000 kHz * 6 us

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N_PH-1:0] req_hi = '0;
  logic [N_PH-1:0] req_lo = '0;
  logic [DT_W-1:0] dt_cycles = '0;
  logic            dt_use_default = 1'b0;
  logic [N_PH-1:0] gate_hi;
  logic [N_PH-1:0] gate_lo;

  int total = 0;
  int bad = 0;
  int overlap = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gate_deadtime_seq #(.N_PH(N_PH), .DT_W(DT_W), .CLK_KHZ(1000),
                      .HOLD_US(20), .DEF_DT_NS(6000)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_hi(req_hi), .req_lo(req_lo),
    .dt_cycles(dt_cycles), .dt_use_default(dt_use_default),
    .gate_hi(gate_hi), .gate_lo(gate_lo));

  always @(negedge clk) if ((gate_hi & gate_lo) != '0) overlap++;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 60000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int first;
    int seen;
    // R6: reset state
    req_hi = 3'b001; req_lo = 3'b110; dt_cycles = 0;
    repeat (3) tick();
    chk(gate_hi == 0 && gate_lo == 0, "R6 reset", {gate_hi, gate_lo}, 0);
    // R7: hold-off from power-up with D = 0
    rst_n = 1'b1;
    first = 0;
    for (int i = 1; i <= HOLD + 6; i++) begin
      tick();
      if (((gate_hi | gate_lo) != 0) && first == 0) first = i;
    end
    chk(first == HOLD + 1, "R7 holdoff", first, HOLD + 1);
    chk(gate_hi == 3'b001 && gate_lo == 3'b110, "R7 drive after holdoff", {gate_hi, gate_lo}, 6'b001110);
    req_hi = 0; req_lo = 0;
    repeat (3) tick();

    // R2/R3/R5/R9 sweep over legs, strap and every dead-time value
    for (int ph = 0; ph < N_PH; ph++) begin
      for (int ds = 0; ds < 2; ds++) begin
        for (int dt = 0; dt < 16; dt++) begin
          int d;
          int off_at;
          int others;
          d = ds ? DEF : dt;
          dt_cycles = DT_W'(dt); dt_use_default = ds[0];
          others = 0;
          req_lo[ph] = 1'b1;
          repeat (d + 2) tick();
          chk(gate_lo[ph] == 1'b1, "R2 lo on", gate_lo[ph], 1);
          req_lo[ph] = 1'b0; req_hi[ph] = 1'b1;
          first = 0; off_at = 0;
          for (int i = 1; i <= d + 4; i++) begin
            tick();
            if (!gate_lo[ph] && off_at == 0) off_at = i;
            if (gate_hi[ph] && first == 0) first = i;
            if (((gate_hi | gate_lo) & ~(3'b001 << ph)) != 0) others++;
          end
          chk(off_at == 1, "R3 lo off", off_at, 1);
          chk(first == d + 1, ds ? "R5 default hi" : "R2 hi delay", first, d + 1);
          req_hi[ph] = 1'b0; req_lo[ph] = 1'b1;
          first = 0; off_at = 0;
          for (int i = 1; i <= d + 4; i++) begin
            tick();
            if (!gate_hi[ph] && off_at == 0) off_at = i;
            if (gate_lo[ph] && first == 0) first = i;
            if (((gate_hi | gate_lo) & ~(3'b001 << ph)) != 0) others++;
          end
          chk(off_at == 1, "R3 hi off", off_at, 1);
          chk(first == d + 1, ds ? "R5 default lo" : "R2 lo delay", first, d + 1);
          chk(others == 0, "R9 other legs idle", others, 0);
          req_lo = 0; req_hi = 0;
          repeat (2) tick();
        end
      end
    end
    dt_use_default = 1'b0;

    // R3: cancel when request drops one edge short of turn-on
    dt_cycles = 8; seen = 0;
    req_hi[1] = 1'b1;
    repeat (8) begin tick(); if (gate_hi[1]) seen++; end
    req_hi[1] = 1'b0;
    repeat (12) begin tick(); if (gate_hi[1]) seen++; end
    chk(seen == 0, "R3 cancel", seen, 0);
    req_hi[1] = 1'b1;
    repeat (9) tick();
    chk(gate_hi[1] == 1'b1, "R2 restart from zero", gate_hi[1], 1);
    req_hi[1] = 1'b0;
    tick();
    chk(gate_hi[1] == 1'b0, "R3 immediate off", gate_hi[1], 0);

    // R4: both requests high
    dt_cycles = 2;
    req_hi[2] = 1'b1;
    repeat (4) tick();
    chk(gate_hi[2] == 1'b1, "R4 setup", gate_hi[2], 1);
    req_lo[2] = 1'b1; seen = 0;
    repeat (10) begin tick(); if (gate_hi[2] || gate_lo[2]) seen++; end
    chk(seen == 0, "R4 conflict off", seen, 0);
    req_hi[2] = 1'b0; first = 0;
    for (int i = 1; i <= 8; i++) begin
      tick();
      if (gate_lo[2] && first == 0) first = i;
    end
    chk(first == 3, "R4 resume lo", first, 3);
    req_lo = 0;
    repeat (3) tick();

    // R8: continuous on
    dt_cycles = 3;
    req_hi[0] = 1'b1;
    repeat (4) tick();
    chk(gate_hi[0] == 1'b1, "R8 on", gate_hi[0], 1);
    seen = 0;
    repeat (400) begin tick(); if (!gate_hi[0]) seen++; end
    chk(seen == 0, "R8 no forced off", seen, 0);

    // R6/R7: reset in mid-run, then hold-off again with D = 3
    rst_n = 1'b0;
    #1;
    chk(gate_hi == 0 && gate_lo == 0, "R6 async reset", {gate_hi, gate_lo}, 0);
    repeat (3) tick();
    chk(gate_hi == 0 && gate_lo == 0, "R6 held in reset", {gate_hi, gate_lo}, 0);
    rst_n = 1'b1;
    first = 0;
    for (int i = 1; i <= HOLD + 10; i++) begin
      tick();
      if (((gate_hi | gate_lo) != 0) && first == 0) first = i;
    end
    chk(first == HOLD + 4, "R7 holdoff after reset", first, HOLD + 4);
    req_hi = 0;
    repeat (2) tick();

    chk(overlap == 0, "R1 no overlap", overlap, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule